// File: doc/BRIEF.md
# Full-Cycle Shift-Register Sequence Generator

This block is an 8-bit pseudo-random sequence generator built from a right-shifting register with linear feedback. A plain linear-feedback register has one state it can never leave: all zeros with XOR feedback, or all ones with XNOR feedback. That state is missing from its 255-state cycle. Here a small correction term is added to the feedback bit. It splices that one state into the cycle between its two neighbours, so the register steps through all 256 values and has no state it can get stuck in.

Because no value is outside the cycle, any value is safe. A value forced into the register by a parallel load, by reset or by an upset rejoins the sequence on the next enabled step, with no outside help. The register shifts right and the new bit enters the top stage. The lowest stage is also offered as a serial bit stream. A parameter selects XOR or XNOR feedback, and the spliced state follows that choice.

Top module: `fullcycle_seq`

## Requirements
- R1: A synchronous reset drives the state to 8'h00 at the next rising edge. Reset overrides both load and enable.
- R2: When load is high and reset is low, the state takes the value of load_value at the next edge, whatever enable is.
- R3: When reset, load and enable are all low, the state does not change.
- R4: On an enabled step (enable high, load and reset low), new state[6:0] equals old state[7:1]. serial_out always equals state[0].
- R5: With XOR polarity, the bit shifted into state[7] is state[0]^state[2]^state[3]^state[4], for every state except 8'h01 and 8'h00.
- R6: With XOR polarity, enabled steps take 8'h01 to 8'h00, and 8'h00 to 8'h80.
- R7: Starting from reset, 256 enabled steps bring the state back to its start value, and each of the 256 values appears exactly once in those steps. This holds for both polarities.
- R8: After any of the 256 possible values is loaded, the next enabled step gives the successor defined by R5/R6 (or R9). No value is a lockup state.
- R9: With XNOR polarity, the shifted-in bit is the inverse of the R5 tap XOR. Enabled steps take 8'hFE to 8'hFF, and 8'hFF to 8'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Replace the state with load_value (has priority over en) |
| load_value | input | 8 | Value written into the register by load |
| state | output | 8 | Current register contents |
| serial_out | output | 1 | Lowest stage of the register |

## Verification
The clocked properties assume that reset is high at the first rising edge, so the state is known before any property is armed. They also assume that load_value is a known value whenever load is high. The bench holds reset high from time zero, and changes every input only on falling edges to known values. The sweeps cover a full period of the sequence from reset for both polarities, every possible loaded value followed by one step, a hold with enable low, a load with enable low, and a reset issued together with load.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  // Feedback polarity: the spliced state is all zeros for XOR, all ones for XNOR
  typedef enum logic {
    POL_XOR  = 1'b0,
    POL_XNOR = 1'b1
  } fb_pol_e;

  localparam int unsigned FCS_WIDTH = 8;

endpackage

// File: rtl/fullcycle_seq_fb.sv
module fullcycle_seq_fb #(
  parameter int unsigned      WIDTH    = fcs_pkg::FCS_WIDTH,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'h1D,
  parameter fcs_pkg::fb_pol_e POLARITY = fcs_pkg::POL_XOR
) (
  input  logic [WIDTH-1:0] cur,
  output logic             fb_bit
);
  localparam logic SPLICE_BIT = (POLARITY == fcs_pkg::POL_XNOR);

  logic lin_fb;
  logic near_splice;

  // Linear part of the feedback; the polarity picks XOR or XNOR
  generate
    if (POLARITY == fcs_pkg::POL_XNOR) begin : g_xnor
      assign lin_fb = ~(^(cur & TAP_MASK));
    end else begin : g_xor
      assign lin_fb = ^(cur & TAP_MASK);
    end
  endgenerate

  // Upper stages all equal the splice bit: this is the spliced state or its predecessor
  assign near_splice = (cur[WIDTH-1:1] == {(WIDTH-1){SPLICE_BIT}});

  assign fb_bit = lin_fb ^ near_splice;

endmodule

// File: rtl/fullcycle_seq_reg.sv
module fullcycle_seq_reg #(
  parameter int unsigned WIDTH = fcs_pkg::FCS_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_value,
  input  logic             fb_bit,
  output logic [WIDTH-1:0] q
);

  // Priority: reset, then load, then shift
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_value;
    else if (en)   q <= {fb_bit, q[WIDTH-1:1]};
  end

  assert_load_priority_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(load_value)));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(q));

endmodule

// File: rtl/fullcycle_seq.sv
module fullcycle_seq #(
  parameter int unsigned      WIDTH    = fcs_pkg::FCS_WIDTH,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'h1D,
  parameter fcs_pkg::fb_pol_e POLARITY = fcs_pkg::POL_XOR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_value,
  output logic [WIDTH-1:0] state,
  output logic             serial_out
);
  localparam logic             K     = (POLARITY == fcs_pkg::POL_XNOR);
  localparam logic [WIDTH-1:0] SPL   = {WIDTH{K}};
  localparam logic [WIDTH-1:0] PRED  = {{(WIDTH-1){K}}, ~K};
  localparam logic [WIDTH-1:0] SUCC  = {~K, {(WIDTH-1){K}}};

  logic fb_bit;

  fullcycle_seq_fb #(
    .WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .POLARITY(POLARITY)
  ) u_fb (
    .cur(state),
    .fb_bit(fb_bit)
  );

  fullcycle_seq_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk),
    .rst(rst),
    .en(en),
    .load(load),
    .load_value(load_value),
    .fb_bit(fb_bit),
    .q(state)
  );

  assign serial_out = state[0];

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (state == '0));

  assert_shift_right_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> (state[WIDTH-2:0] == $past(state[WIDTH-1:1])));

  // R6 / R9: entry into the spliced state
  assert_splice_enter_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == PRED) |=> (state == SPL));

  // R6 / R9: exit from the spliced state
  assert_splice_leave_R9: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == SPL) |=> (state == SUCC));

endmodule

// File: tb/fullcycle_seq_bench.sv
`timescale 1ns/1ps
module fullcycle_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_value = 8'h00;
  logic [7:0] sx, sn;
  logic       ox, on;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [7:0] mx = 8'h00;
  logic [7:0] mn = 8'h00;

  fullcycle_seq u_fullcycle_seq (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_value(load_value),
    .state(sx), .serial_out(ox)
  );

  fullcycle_seq #(.POLARITY(fcs_pkg::POL_XNOR)) u_fullcycle_seq_xnor (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_value(load_value),
    .state(sn), .serial_out(on)
  );

  // Successor from R5/R6 (inv=0) and R9 (inv=1)
  function automatic logic [7:0] model_next(logic [7:0] s, bit inv);
    logic fb;
    fb = s[0] ^ s[2] ^ s[3] ^ s[4];
    if (inv) fb = ~fb;
    if (s[7:1] == {7{inv}}) fb = ~fb;
    return {fb, s[7:1]};
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit e, bit l, logic [7:0] v);
    @(negedge clk);
    rst = r; en = e; load = l; load_value = v;
    @(posedge clk);
    #1;
    if (r) begin mx = 8'h00; mn = 8'h00; end
    else if (l) begin mx = v; mn = v; end
    else if (e) begin mx = model_next(mx, 1'b0); mn = model_next(mn, 1'b1); end
  endtask

  task automatic cmp(string req);
    chk(sx == mx, req, sx, mx);
    chk(sn == mn, req, sn, mn);
  endtask

  initial begin
    bit seen_x [256];
    bit seen_n [256];
    int dup_x, dup_n, cnt_x, cnt_n;
    logic [7:0] px, pn;

    cyc(1, 0, 0, 8'h00);
    cyc(1, 0, 0, 8'h00);
    cmp("R1 reset state");
    chk(ox == 1'b0, "R1 serial after reset", {7'd0, ox}, 8'h00);

    // Full period from reset, both polarities
    dup_x = 0; dup_n = 0;
    for (int i = 1; i <= 256; i++) begin
      px = sx; pn = sn;
      cyc(0, 1, 0, 8'h00);
      cmp("R5 step");
      chk(sx[6:0] == px[7:1], "R4 shift", sx, {1'b0, px[7:1]});
      chk(ox == sx[0], "R4 serial", {7'd0, ox}, {7'd0, sx[0]});
      if (px == 8'h01) chk(sx == 8'h00, "R6 enter zero", sx, 8'h00);
      if (px == 8'h00) chk(sx == 8'h80, "R6 leave zero", sx, 8'h80);
      if (pn == 8'hFE) chk(sn == 8'hFF, "R9 enter ones", sn, 8'hFF);
      if (pn == 8'hFF) chk(sn == 8'h7F, "R9 leave ones", sn, 8'h7F);
      if (seen_x[sx]) dup_x++;
      if (seen_n[sn]) dup_n++;
      seen_x[sx] = 1'b1;
      seen_n[sn] = 1'b1;
    end
    cnt_x = 0; cnt_n = 0;
    for (int v = 0; v < 256; v++) begin
      if (seen_x[v]) cnt_x++;
      if (seen_n[v]) cnt_n++;
    end
    chk(sx == 8'h00, "R7 period xor", sx, 8'h00);
    chk(sn == 8'h00, "R7 period xnor", sn, 8'h00);
    chk(dup_x == 0 && cnt_x == 256, "R7 coverage xor", cnt_x[7:0], 8'h00);
    chk(dup_n == 0 && cnt_n == 256, "R7 coverage xnor", cnt_n[7:0], 8'h00);

    // Hold with enable low
    cyc(0, 1, 0, 8'h00);
    cyc(0, 1, 0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 8'hFF);
      cmp("R3 hold");
    end

    // Load with enable low
    cyc(0, 0, 1, 8'hA5);
    cmp("R2 load en low");
    chk(sx == 8'hA5, "R2 load value", sx, 8'hA5);

    // Every value loaded (enable high: load wins), then one step
    for (int v = 0; v < 256; v++) begin
      cyc(0, 1, 1, v[7:0]);
      chk(sx == v[7:0], "R2 load priority", sx, v[7:0]);
      chk(sn == v[7:0], "R2 load priority", sn, v[7:0]);
      cyc(0, 1, 0, 8'h00);
      cmp("R8 rejoin");
    end

    // Reset overrides load
    cyc(1, 1, 1, 8'h3C);
    cmp("R1 reset over load");
    cyc(0, 0, 0, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule